// File: doc/BRIEF.md
# Regulator Power-Good Window Monitor

This block drives the power-good indication of a switching regulator. It looks at two digitized window comparators on the feedback node, one that trips above the upper regulation limit and one that trips below the lower limit. It also looks at the fault supervisor's active flag, a soft-start completion flag and a one-clock strobe that marks each switching period. The output is an active-high level standing in for an open-drain line, so a low level means "not good".

Power-good rises only after the output has been inside the window for a fixed number of switching periods. Because the delay is counted in switching periods and not in system clocks, its length in time scales with the inverse of the switching frequency. A count of 500 periods gives about 1 ms at 500 kHz. Leaving the window, raising a fault or losing soft-start-done pulls the output low on the next system clock and clears the delay count. The analog thresholds, which sit near 111 % and 90 % of the reference with about 1 % hysteresis, and the comparators themselves are upstream of this block.

Top module: `power_good_mon`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `pgood` is low and the delay count is cleared. After reset, a full delay is needed before `pgood` can rise.
- R2: A clock edge that samples `fb_above_hi` high leaves `pgood` low after that edge.
- R3: A clock edge that samples `fb_below_lo` high leaves `pgood` low after that edge.
- R4: A clock edge that samples `fault_act` high leaves `pgood` low after that edge. This also holds for a long fault, such as a hiccup wait.
- R5: While `ss_done` is low, `pgood` stays low and `sw_strobe` pulses are not counted.
- R6: With the inputs qualified, meaning `ss_done` high and the other three condition inputs low, the edge that samples the DELAY_CYC-th qualified `sw_strobe` completes the count. `pgood` goes high on the following clock edge.
- R7: After only DELAY_CYC-1 qualified strobes, `pgood` is still low, however many clocks pass.
- R8: Any clock on which the inputs are not qualified clears the count. After such a clock, a full DELAY_CYC fresh qualified strobes are needed again.
- R9: Deassertion takes at most one system clock from the edge that samples the disqualifying input. There is no filtering or delay.
- R10: Once `pgood` is high, further strobes keep it high while the inputs stay qualified. The count saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_above_hi | input | 1 | Feedback above the upper window limit |
| fb_below_lo | input | 1 | Feedback below the lower window limit |
| fault_act | input | 1 | Fault supervisor reports an active fault or hiccup wait |
| ss_done | input | 1 | Soft-start has completed |
| sw_strobe | input | 1 | One-clock pulse per switching period |
| pgood | output | 1 | Power good, active high (low = not good) |

## Verification
The bench targets the off-by-one boundary of the delay:
- A count that compared against DELAY_CYC-1 would raise `pgood` one period early, after DELAY_CYC-1 strobes.
- A design that counted every clock instead of every strobe would rise far too soon.

It also disqualifies the inputs for a single clock partway through a count, then checks that the full delay is needed again; a design that merely paused the counter would rise early. Strobes sent before soft-start-done are checked to be ignored. Each of the three disqualifying inputs is pulsed while `pgood` is high, which catches any added latency or a missing term. Long runs of extra strobes catch a count that wraps and drops `pgood`.

// File: rtl/pg_pkg.sv
package pg_pkg;
  // Width needed to hold values 0..max_val
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction
endpackage

// File: rtl/pg_qualify.sv
module pg_qualify (
  input  logic above_hi,
  input  logic below_lo,
  input  logic fault,
  input  logic ss_ok,
  output logic in_reg_ok
);
  // Output is in regulation and nothing blocks the indication
  always_comb begin
    in_reg_ok = ss_ok & ~above_hi & ~below_lo & ~fault;
  end
endmodule

// File: rtl/pg_delay_cnt.sv
module pg_delay_cnt #(
  parameter int DELAY_CYC = 500,
  localparam int CW = pg_pkg::cnt_width(DELAY_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic qual,
  input  logic tick,
  output logic expired
);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !qual) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    expired = (cnt_q == LIMIT);
  end
endmodule

// File: rtl/power_good_mon.sv
module power_good_mon #(
  parameter int DELAY_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_above_hi,
  input  logic fb_below_lo,
  input  logic fault_act,
  input  logic ss_done,
  input  logic sw_strobe,
  output logic pgood
);
  logic qual_now;
  logic dly_expired;
  logic pgood_q;

  pg_qualify u_qual (
    .above_hi  (fb_above_hi),
    .below_lo  (fb_below_lo),
    .fault     (fault_act),
    .ss_ok     (ss_done),
    .in_reg_ok (qual_now)
  );

  pg_delay_cnt #(.DELAY_CYC(DELAY_CYC)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .qual    (qual_now),
    .tick    (sw_strobe),
    .expired (dly_expired)
  );

  // Registered output: rises one clock after the count completes,
  // drops on the first edge that sees a disqualifying input.
  always_ff @(posedge clk) begin
    if (rst) begin
      pgood_q <= 1'b0;
    end else begin
      pgood_q <= qual_now & dly_expired;
    end
  end

  assign pgood = pgood_q;
endmodule

// File: rtl/power_good_mon_chk.sv
module power_good_mon_chk #(
  parameter int DELAY_CYC = 500
) (
  input logic clk,
  input logic rst,
  input logic fb_above_hi,
  input logic fb_below_lo,
  input logic fault_act,
  input logic ss_done,
  input logic sw_strobe,
  input logic pgood
);
  // Independent tally of qualified strobes, saturating
  int unsigned seen_q;
  always_ff @(posedge clk) begin
    if (rst || !ss_done || fb_above_hi || fb_below_lo || fault_act) begin
      seen_q <= 0;
    end else if (sw_strobe && seen_q < DELAY_CYC) begin
      seen_q <= seen_q + 1;
    end
  end

  // R1
  rst_low_chk: assert property (@(posedge clk) rst |=> !pgood);
  // R2
  above_drop_chk: assert property (@(posedge clk) disable iff (rst) fb_above_hi |=> !pgood);
  // R3
  below_drop_chk: assert property (@(posedge clk) disable iff (rst) fb_below_lo |=> !pgood);
  // R4
  fault_drop_chk: assert property (@(posedge clk) disable iff (rst) fault_act |=> !pgood);
  // R5
  ss_hold_chk: assert property (@(posedge clk) disable iff (rst) !ss_done |=> !pgood);
  // R6
  full_delay_chk: assert property (@(posedge clk) disable iff (rst) $rose(pgood) |-> seen_q >= DELAY_CYC);
  // R10
  stay_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pgood && ss_done && !fb_above_hi && !fb_below_lo && !fault_act) |=> pgood);
endmodule

bind power_good_mon power_good_mon_chk #(.DELAY_CYC(DELAY_CYC)) u_chk (
  .clk(clk), .rst(rst), .fb_above_hi(fb_above_hi), .fb_below_lo(fb_below_lo),
  .fault_act(fault_act), .ss_done(ss_done), .sw_strobe(sw_strobe), .pgood(pgood)
);

// File: tb/power_good_mon_bench.sv
module power_good_mon_bench;
  localparam int D = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_above_hi = 1'b0;
  logic fb_below_lo = 1'b0;
  logic fault_act = 1'b0;
  logic ss_done = 1'b0;
  logic sw_strobe = 1'b0;
  logic pgood;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    bit    exp;
    string req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  power_good_mon #(.DELAY_CYC(D)) u_power_good_mon (
    .clk(clk), .rst(rst), .fb_above_hi(fb_above_hi), .fb_below_lo(fb_below_lo),
    .fault_act(fault_act), .ss_done(ss_done), .sw_strobe(sw_strobe), .pgood(pgood)
  );

  // Driver: apply one clock of stimulus, push the expected post-edge output
  task automatic step(input bit r, input bit hi, input bit lo, input bit flt,
                      input bit ss, input bit stb, input string req);
    bit ok;
    item_t it;
    @(negedge clk);
    rst = r; fb_above_hi = hi; fb_below_lo = lo; fault_act = flt;
    ss_done = ss; sw_strobe = stb;
    @(posedge clk);
    ok = ss && !hi && !lo && !flt;
    if (r) begin
      it.exp = 1'b0;
      m_cnt = 0;
    end else begin
      it.exp = ok && (m_cnt == D);
      if (!ok) m_cnt = 0;
      else if (stb && m_cnt < D) m_cnt = m_cnt + 1;
    end
    it.req = req;
    sb.push_back(it);
  endtask

  // n qualified strobes, each followed by gap idle qualified clocks
  task automatic strobes(input int n, input int gap, input string req);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 1, 1, req);
      for (int g = 0; g < gap; g++) step(0, 0, 0, 0, 1, 0, req);
    end
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (pgood !== it.exp) begin
        errors++;
        $display("FAIL %s: pgood=%b expected=%b at %0t", it.req, pgood, it.exp, $time);
      end
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 1, "R1");
    // R5: strobes before soft-start done are ignored
    for (int i = 0; i < D + 3; i++) step(0, 0, 0, 0, 0, 1, "R5");
    // R7: one short of the delay, then long idle
    strobes(D - 1, 2, "R7");
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 0, "R7");
    // R6: final strobe completes count, rise next clock
    strobes(1, 3, "R6");
    // R10: saturation under many extra strobes
    strobes(2 * D, 1, "R10");
    // R2 / R9: above-window single clock drops output at once
    step(0, 1, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R9");
    // R8: count restarted, partial then one-clock glitch then restart
    strobes(D / 2, 1, "R8");
    step(0, 0, 1, 0, 1, 1, "R8");
    strobes(D - 1, 1, "R8");
    strobes(1, 2, "R8");
    // R3: below-window drop
    step(0, 0, 1, 0, 1, 1, "R3");
    strobes(D, 0, "R3");
    step(0, 0, 0, 0, 1, 0, "R3");
    // R4: long fault (hiccup wait) with strobes running
    for (int i = 0; i < 2 * D; i++) step(0, 0, 0, 1, 1, 1, "R4");
    strobes(D, 1, "R4");
    // R5: loss of soft-start done drops the output
    step(0, 0, 0, 0, 0, 0, "R5");
    strobes(D, 0, "R5");
    // R1: reset mid-operation clears the count
    step(1, 0, 0, 0, 1, 1, "R1");
    strobes(D - 1, 0, "R1");
    strobes(1, 2, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule